// File: doc/BRIEF.md
# Multi-Width Integer Divider with Flags

This block is an iterative restoring divider for a processor execution unit. One operation is launched with a single-cycle `start` pulse. It covers three operand shapes: a 32-bit dividend over a 16-bit divisor, a 32-bit dividend over a 32-bit divisor, and a 64-bit dividend over a 32-bit divisor. Each shape runs either signed or unsigned. The block produces one quotient bit per clock. It then presents its results as at most two register-write requests, together with the four condition flags and a divide-by-zero trap request.

The register file and exception dispatch sit outside the block. The block only reports which writes to perform, to which register indices, with what data, and whether the flags are to be updated. Overflow leaves both destinations untouched. The short form packs remainder and quotient into one 32-bit word. The long forms return quotient and remainder separately. When both destination indices name the same register, the quotient wins.

Top module: `mwdiv_top`

## Requirements
- R1: A zero divisor (for `size`=0 only `divisor[15:0]` counts) makes `done` and `trap_div0` rise one clock edge after `start` is sampled, with `wr_a_en`, `wr_b_en` and `flag_we` all low.
- R2: Whenever `flag_we` is high, `flag_c` is 0, including on overflow.
- R3: For `size`=0 the divisor is `divisor[15:0]` and the dividend is `dividend_lo`. The single result goes out on port B to `quo_idx` as `{remainder[15:0], quotient[15:0]}`, and port A stays low.
- R4: For `size`=0, an unsigned divide overflows when the quotient exceeds 0xFFFF. A signed divide overflows when the quotient lies outside -32768..32767.
- R5: On overflow, `flag_v`=1, `flag_z`=0, `flag_n` equals `n_prev` as sampled with `start`, and neither write port is enabled.
- R6: Without overflow, `flag_v`=0. `flag_n` is the top bit of the quotient (bit 15 for `size`=0, bit 31 otherwise), and `flag_z` is 1 exactly when that quotient is zero.
- R7: For `size`=2 or 3 the dividend is `{dividend_hi, dividend_lo}`. For `size`=1 it is `dividend_lo`, zero- or sign-extended. Both overflow when the quotient does not fit 32 bits, unsigned or signed as selected by `is_signed`.
- R8: For `size`=1..3 without overflow, port B carries the 32-bit quotient to `quo_idx` and port A carries the 32-bit remainder to `rem_idx`. When the two indices are equal, only port B is enabled.
- R9: Signed quotients truncate toward zero. A signed remainder takes the sign of the dividend, and its magnitude is below that of the divisor.
- R10: `done` is high for exactly one cycle. It rises 33 edges after the edge that samples `start` (65 for `size`=2 or 3). `busy` is high from that edge until `done` falls, and a `start` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled when idle |
| size | input | 2 | 0: 32/16, 1: 32/32, 2 or 3: 64/32 |
| is_signed | input | 1 | Two's complement operands when 1 |
| dividend_hi | input | 32 | Upper dividend word (64/32 only) |
| dividend_lo | input | 32 | Lower dividend word |
| divisor | input | 32 | Divisor |
| quo_idx | input | 3 | Destination index for the quotient |
| rem_idx | input | 3 | Destination index for the remainder |
| n_prev | input | 1 | Current N flag, kept on overflow |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| trap_div0 | output | 1 | Divide-by-zero trap request |
| wr_a_en | output | 1 | Remainder write enable |
| wr_a_idx | output | 3 | Remainder write index |
| wr_a_data | output | 32 | Remainder write data |
| wr_b_en | output | 1 | Quotient write enable |
| wr_b_idx | output | 3 | Quotient write index |
| wr_b_data | output | 32 | Quotient (or packed word) write data |
| flag_we | output | 1 | Flag update enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The remainder write and the quotient write are produced in the same `done` cycle. When the two indices match, they collide on one register. The bench provokes this by issuing a long divide with `quo_idx` equal to `rem_idx`. It then judges that port A stays low while port B carries the quotient. A second collision is a fresh `start` arriving mid-run: the bench pulses `start` with different operands while `busy` is high and confirms that the first result is delivered unchanged and that no second run follows.

// File: rtl/mwdiv_pkg.sv
package mwdiv_pkg;

    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_LONG = 2'd1,
        SZ_QUAD = 2'd2,
        SZ_QALT = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } state_e;

    typedef struct packed {
        size_e size;
        logic  sgn;
        logic  q_neg;
        logic  r_neg;
        logic  n_prev;
    } meta_t;

    function automatic logic is_word(input size_e s);
        return s == SZ_WORD;
    endfunction

    function automatic logic is_wide(input size_e s);
        return s[1];
    endfunction

endpackage

// File: rtl/mwdiv_prep.sv
module mwdiv_prep
    import mwdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  size_e          size,
    input  logic           sgn,
    input  logic [W-1:0]   dvd_hi,
    input  logic [W-1:0]   dvd_lo,
    input  logic [W-1:0]   dvs,
    output logic [2*W-1:0] dmag,
    output logic [W-1:0]   vmag,
    output logic           q_neg,
    output logic           r_neg,
    output logic           vzero
);
    localparam int D = 2 * W;
    localparam int H = W / 2;
    localparam logic [D-1:0] ONE_D = 1;
    localparam logic [W-1:0] ONE_W = 1;

    logic [D-1:0] dvd_ext;
    logic [W-1:0] dvs_ext;
    logic         dneg;
    logic         vneg;

    always_comb begin
        if (is_wide(size))
            dvd_ext = {dvd_hi, dvd_lo};
        else if (sgn)
            dvd_ext = {{W{dvd_lo[W-1]}}, dvd_lo};
        else
            dvd_ext = {{W{1'b0}}, dvd_lo};

        if (is_word(size))
            dvs_ext = sgn ? {{(W-H){dvs[H-1]}}, dvs[H-1:0]} : {{(W-H){1'b0}}, dvs[H-1:0]};
        else
            dvs_ext = dvs;

        dneg  = sgn & dvd_ext[D-1];
        vneg  = sgn & dvs_ext[W-1];
        dmag  = dneg ? (~dvd_ext + ONE_D) : dvd_ext;
        vmag  = vneg ? (~dvs_ext + ONE_W) : dvs_ext;
        q_neg = dneg ^ vneg;
        r_neg = dneg;
        vzero = (dvs_ext == '0);
    end

endmodule

// File: rtl/mwdiv_iter.sv
module mwdiv_iter
    import mwdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic           vzero,
    input  logic           wide_run,
    input  logic [2*W-1:0] dmag,
    input  logic [W-1:0]   vmag,
    output logic           busy,
    output logic           done,
    output logic           trap,
    output logic [2*W-1:0] quo,
    output logic [W-1:0]   rem
);
    localparam int D  = 2 * W;
    localparam int CW = $clog2(D);

    state_e         state;
    logic [CW-1:0]  cnt;
    logic [D-1:0]   sh;
    logic [W-1:0]   div_r;
    logic [W+1:0]   cat;
    logic [W+1:0]   diff;
    logic           fits;
    logic [W-1:0]   nrem;

    // one restoring step: bring down the next dividend bit, trial subtract
    always_comb begin
        cat  = {1'b0, rem, sh[D-1]};
        diff = cat - {2'b00, div_r};
        fits = ~diff[W+1];
        nrem = fits ? diff[W-1:0] : {rem[W-2:0], sh[D-1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sh    <= '0;
            div_r <= '0;
            rem   <= '0;
            quo   <= '0;
            trap  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (go) begin
                    trap  <= vzero;
                    div_r <= vmag;
                    rem   <= '0;
                    quo   <= '0;
                    sh    <= wide_run ? dmag : {dmag[W-1:0], {W{1'b0}}};
                    cnt   <= wide_run ? CW'(D-1) : CW'(W-1);
                    state <= vzero ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    rem <= nrem;
                    quo <= {quo[D-2:0], fits};
                    sh  <= {sh[D-2:0], 1'b0};
                    if (cnt == '0)
                        state <= ST_FIN;
                    else
                        cnt <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FIN);

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (rem < div_r)); // R9

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_ZERO_FINISHES_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
        (go && vzero && !busy) |=> (done && trap)); // R1

endmodule

// File: rtl/mwdiv_fmt.sv
module mwdiv_fmt
    import mwdiv_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 3
) (
    input  logic           done,
    input  logic           trap,
    input  logic [2*W-1:0] quo,
    input  logic [W-1:0]   rem,
    input  meta_t          meta,
    input  logic [IW-1:0]  qidx,
    input  logic [IW-1:0]  ridx,
    output logic           trap_div0,
    output logic           wr_a_en,
    output logic [IW-1:0]  wr_a_idx,
    output logic [W-1:0]   wr_a_data,
    output logic           wr_b_en,
    output logic [IW-1:0]  wr_b_idx,
    output logic [W-1:0]   wr_b_data,
    output logic           flag_we,
    output logic           flag_n,
    output logic           flag_z,
    output logic           flag_v,
    output logic           flag_c
);
    localparam int D = 2 * W;
    localparam int H = W / 2;
    localparam logic [D-1:0] ONE_D  = 1;
    localparam logic [W-1:0] ONE_W  = 1;
    localparam logic [D-1:0] LIM_WU = (ONE_D << H) - ONE_D;
    localparam logic [D-1:0] LIM_WP = (ONE_D << (H-1)) - ONE_D;
    localparam logic [D-1:0] LIM_WN = ONE_D << (H-1);
    localparam logic [D-1:0] LIM_LU = (ONE_D << W) - ONE_D;
    localparam logic [D-1:0] LIM_LP = (ONE_D << (W-1)) - ONE_D;
    localparam logic [D-1:0] LIM_LN = ONE_D << (W-1);

    logic [D-1:0] lim;
    logic         ovf;
    logic         word;
    logic         ok;
    logic [W-1:0] q_s;
    logic [W-1:0] r_s;

    always_comb begin
        word = is_word(meta.size);
        if (word)
            lim = !meta.sgn ? LIM_WU : (meta.q_neg ? LIM_WN : LIM_WP);
        else
            lim = !meta.sgn ? LIM_LU : (meta.q_neg ? LIM_LN : LIM_LP);
        ovf = (quo > lim);

        q_s = meta.q_neg ? (~quo[W-1:0] + ONE_W) : quo[W-1:0];
        r_s = meta.r_neg ? (~rem + ONE_W) : rem;

        ok        = done & ~trap & ~ovf;
        trap_div0 = done & trap;
        flag_we   = done & ~trap;

        wr_b_en   = ok;
        wr_b_idx  = qidx;
        wr_b_data = word ? {r_s[H-1:0], q_s[H-1:0]} : q_s;

        // quotient wins a shared destination: drop the remainder write
        wr_a_en   = ok & ~word & (ridx != qidx);
        wr_a_idx  = ridx;
        wr_a_data = r_s;

        flag_v = ovf;
        flag_c = 1'b0;
        if (ovf) begin
            flag_n = meta.n_prev;
            flag_z = 1'b0;
        end else if (word) begin
            flag_n = q_s[H-1];
            flag_z = (q_s[H-1:0] == '0);
        end else begin
            flag_n = q_s[W-1];
            flag_z = (q_s == '0);
        end
    end

endmodule

// File: rtl/mwdiv_top.sv
module mwdiv_top
    import mwdiv_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    size,
    input  logic          is_signed,
    input  logic [W-1:0]  dividend_hi,
    input  logic [W-1:0]  dividend_lo,
    input  logic [W-1:0]  divisor,
    input  logic [IW-1:0] quo_idx,
    input  logic [IW-1:0] rem_idx,
    input  logic          n_prev,
    output logic          busy,
    output logic          done,
    output logic          trap_div0,
    output logic          wr_a_en,
    output logic [IW-1:0] wr_a_idx,
    output logic [W-1:0]  wr_a_data,
    output logic          wr_b_en,
    output logic [IW-1:0] wr_b_idx,
    output logic [W-1:0]  wr_b_data,
    output logic          flag_we,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c
);
    localparam int D = 2 * W;

    size_e          size_in;
    logic           go;
    logic [D-1:0]   dmag;
    logic [W-1:0]   vmag;
    logic           q_neg;
    logic           r_neg;
    logic           vzero;
    logic           trap;
    logic [D-1:0]   quo;
    logic [W-1:0]   rem;
    meta_t          meta_q;
    logic [IW-1:0]  qidx_q;
    logic [IW-1:0]  ridx_q;

    assign size_in = size_e'(size);
    assign go      = start & ~busy;

    mwdiv_prep #(.W(W)) i_prep (
        .size   (size_in),
        .sgn    (is_signed),
        .dvd_hi (dividend_hi),
        .dvd_lo (dividend_lo),
        .dvs    (divisor),
        .dmag   (dmag),
        .vmag   (vmag),
        .q_neg  (q_neg),
        .r_neg  (r_neg),
        .vzero  (vzero)
    );

    mwdiv_iter #(.W(W)) i_iter (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .vzero    (vzero),
        .wide_run (is_wide(size_in)),
        .dmag     (dmag),
        .vmag     (vmag),
        .busy     (busy),
        .done     (done),
        .trap     (trap),
        .quo      (quo),
        .rem      (rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            qidx_q <= '0;
            ridx_q <= '0;
        end else if (go) begin
            meta_q <= '{size: size_in, sgn: is_signed, q_neg: q_neg,
                        r_neg: r_neg, n_prev: n_prev};
            qidx_q <= quo_idx;
            ridx_q <= rem_idx;
        end
    end

    mwdiv_fmt #(.W(W), .IW(IW)) i_fmt (
        .done      (done),
        .trap      (trap),
        .quo       (quo),
        .rem       (rem),
        .meta      (meta_q),
        .qidx      (qidx_q),
        .ridx      (ridx_q),
        .trap_div0 (trap_div0),
        .wr_a_en   (wr_a_en),
        .wr_a_idx  (wr_a_idx),
        .wr_a_data (wr_a_data),
        .wr_b_en   (wr_b_en),
        .wr_b_idx  (wr_b_idx),
        .wr_b_data (wr_b_data),
        .flag_we   (flag_we),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .flag_v    (flag_v),
        .flag_c    (flag_c)
    );

    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        trap_div0 |-> (!wr_a_en && !wr_b_en && !flag_we)); // R1

    AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (rst)
        (flag_we && flag_v) |-> (!wr_b_en && !wr_a_en && !flag_z && flag_n == meta_q.n_prev)); // R5

    AST_SHARED_DEST_QUOTIENT: assert property (@(posedge clk) disable iff (rst)
        wr_a_en |-> (wr_b_en && wr_a_idx != wr_b_idx)); // R8

    AST_BUSY_HOLDS_OPERANDS: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(meta_q) && $stable(qidx_q) && $stable(ridx_q))); // R10

    AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R10

endmodule

// File: tb/test_mwdiv_top.sv
module test_mwdiv_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  size = 2'd0;
    logic        is_signed = 1'b0;
    logic [31:0] dividend_hi = '0;
    logic [31:0] dividend_lo = '0;
    logic [31:0] divisor = 32'd1;
    logic [2:0]  quo_idx = '0;
    logic [2:0]  rem_idx = '0;
    logic        n_prev = 1'b0;
    logic        busy, done, trap_div0;
    logic        wr_a_en, wr_b_en;
    logic [2:0]  wr_a_idx, wr_b_idx;
    logic [31:0] wr_a_data, wr_b_data;
    logic        flag_we, flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mwdiv_top i_mwdiv_top (
        .clk(clk), .rst(rst), .start(start), .size(size), .is_signed(is_signed),
        .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
        .quo_idx(quo_idx), .rem_idx(rem_idx), .n_prev(n_prev),
        .busy(busy), .done(done), .trap_div0(trap_div0),
        .wr_a_en(wr_a_en), .wr_a_idx(wr_a_idx), .wr_a_data(wr_a_data),
        .wr_b_en(wr_b_en), .wr_b_idx(wr_b_idx), .wr_b_data(wr_b_data),
        .flag_we(flag_we), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic launch(input logic [1:0] sz, input logic sg, input logic [31:0] hi, input logic [31:0] lo,
                          input logic [31:0] dv, input logic [2:0] qi, input logic [2:0] ri, input logic np);
        @(negedge clk);
        size = sz; is_signed = sg; dividend_hi = hi; dividend_lo = lo; divisor = dv;
        quo_idx = qi; rem_idx = ri; n_prev = np; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic run_case(input string tag, input logic [1:0] sz, input logic sg, input logic [31:0] hi,
                            input logic [31:0] lo, input logic [31:0] dv, input logic [2:0] qi,
                            input logic [2:0] ri, input logic np);
        longint a, b, qq, rr;
        logic [63:0] ua, ub, qv, rv;
        bit word, wide, ez, eo;
        int edges;
        word = (sz == 2'd0);
        wide = sz[1];
        ez = word ? (dv[15:0] == 16'h0) : (dv == 32'h0);
        eo = 0; qv = '0; rv = '0;
        if (!ez) begin
            if (wide && !sg) begin
                ua = {hi, lo}; ub = {32'h0, dv};
                qv = ua / ub; rv = ua % ub;
                eo = |qv[63:32];
            end else begin
                if (wide) a = $signed({hi, lo});
                else if (sg) a = longint'($signed(lo));
                else a = longint'({32'h0, lo});
                if (word) b = sg ? longint'($signed(dv[15:0])) : longint'({48'h0, dv[15:0]});
                else b = sg ? longint'($signed(dv)) : longint'({32'h0, dv});
                qq = a / b; rr = a % b;
                qv = qq; rv = rr;
                if (word) eo = sg ? (qq > 32767 || qq < -32768) : (qq > 65535);
                else eo = sg ? (qq > 64'sd2147483647 || qq < -64'sd2147483648) : (qq > 64'sd4294967295);
            end
        end
        while (busy) begin @(posedge clk); #1; end
        launch(sz, sg, hi, lo, dv, qi, ri, np);
        edges = 1;
        while (!done && edges < 100) begin @(posedge clk); #1; edges++; end
        chk("R10", {tag, " latency"}, edges, ez ? 1 : (wide ? 65 : 33));
        chk("R1", {tag, " trap"}, trap_div0, ez);
        if (ez) begin
            chk("R1", {tag, " no writes"}, {wr_a_en, wr_b_en, flag_we}, 3'b000);
        end else begin
            chk("R2", {tag, " flag_we/C"}, {flag_we, flag_c}, 2'b10);
            chk(word ? "R4" : "R7", {tag, " overflow V"}, flag_v, eo);
            if (eo) begin
                chk("R5", {tag, " ovf keeps dest, Z=0, N kept"}, {wr_a_en, wr_b_en, flag_z, flag_n}, {3'b000, np});
            end else begin
                chk(word ? "R3" : "R8", {tag, " quotient write"}, {wr_b_en, wr_b_idx}, {1'b1, qi});
                if (word) begin
                    chk("R3", {tag, " packed word"}, wr_b_data, {rv[15:0], qv[15:0]});
                    chk("R3", {tag, " no port A"}, wr_a_en, 1'b0);
                    chk("R6", {tag, " N Z"}, {flag_n, flag_z}, {qv[15], qv[15:0] == 16'h0});
                end else begin
                    chk(sg ? "R9" : "R8", {tag, " quotient"}, wr_b_data, qv[31:0]);
                    chk("R8", {tag, " port A enable"}, wr_a_en, qi != ri);
                    if (qi != ri)
                        chk(sg ? "R9" : "R8", {tag, " remainder"}, {wr_a_idx, wr_a_data}, {ri, rv[31:0]});
                    chk("R6", {tag, " N Z"}, {flag_n, flag_z}, {qv[31], qv[31:0] == 32'h0});
                end
            end
        end
        @(posedge clk); #1;
        chk("R10", {tag, " done single cycle"}, done, 1'b0);
    endtask

    task automatic t_reset;
        chk("R10", "reset state", {busy, done, wr_a_en, wr_b_en, flag_we, trap_div0}, 6'b0);
    endtask

    task automatic t_word;
        run_case("word u basic", 2'd0, 0, 0, 32'd100000, 32'hABCD_0007, 3'd1, 3'd0, 0);
        run_case("word u max fits", 2'd0, 0, 0, 32'h0001_FFFE, 32'd2, 3'd2, 3'd0, 0);
        run_case("word u just over", 2'd0, 0, 0, 32'h0001_0000, 32'd1, 3'd2, 3'd0, 1);
        run_case("word u big ovf", 2'd0, 0, 0, 32'hFFFF_FFFF, 32'h0000_FFFF, 3'd2, 3'd0, 0);
        run_case("word zero quotient", 2'd0, 0, 0, 32'd3, 32'd5, 3'd4, 3'd0, 1);
    endtask

    task automatic t_word_signed;
        run_case("word s R9 neg dividend", 2'd0, 1, 0, -32'sd100, 32'd7, 3'd3, 3'd0, 0);
        run_case("word s R9 neg divisor", 2'd0, 1, 0, 32'd100, 32'h0000_FFF9, 3'd3, 3'd0, 0);
        run_case("word s min fits", 2'd0, 1, 0, 32'hFFFF_8000, 32'd1, 3'd3, 3'd0, 0);
        run_case("word s pos ovf", 2'd0, 1, 0, 32'd32768, 32'd1, 3'd3, 3'd0, 0);
        run_case("word s neg ovf", 2'd0, 1, 0, -32'sd32769, 32'd1, 3'd3, 3'd0, 1);
    endtask

    task automatic t_long;
        run_case("long u", 2'd1, 0, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0000_1234, 3'd5, 3'd6, 0);
        run_case("long s R9", 2'd1, 1, 0, -32'sd7, 32'd2, 3'd5, 3'd6, 0);
        run_case("long s min by -1 ovf", 2'd1, 1, 0, 32'h8000_0000, 32'hFFFF_FFFF, 3'd5, 3'd6, 0);
    endtask

    task automatic t_quad;
        run_case("quad u 2^31", 2'd2, 0, 32'd1, 32'd0, 32'd2, 3'd0, 3'd1, 0);
        run_case("quad s 2^31 ovf", 2'd2, 1, 32'd1, 32'd0, 32'd2, 3'd0, 3'd1, 1);
        run_case("quad u ovf", 2'd3, 0, 32'd1, 32'd0, 32'd1, 3'd0, 3'd1, 0);
        run_case("quad s R9 neg", 2'd2, 1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7, 3'd0, 3'd1, 0);
        run_case("quad s min fits", 2'd2, 1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 3'd0, 3'd1, 0);
    endtask

    task automatic t_div0;
        run_case("word R1 zero low half", 2'd0, 0, 0, 32'd50, 32'hFFFF_0000, 3'd1, 3'd2, 0);
        run_case("long R1 zero", 2'd1, 1, 0, 32'd50, 32'd0, 3'd1, 3'd2, 0);
        run_case("quad R1 zero", 2'd2, 0, 32'd9, 32'd50, 32'd0, 3'd1, 3'd2, 0);
    endtask

    task automatic t_same_idx;
        run_case("long R8 same idx", 2'd1, 0, 0, 32'd1000, 32'd7, 3'd3, 3'd3, 0);
        run_case("quad R8 same idx", 2'd2, 1, 32'hFFFF_FFFF, 32'hFFFF_FC18, 32'd7, 3'd6, 3'd6, 0);
    endtask

    task automatic t_busy_ignore;
        int edges;
        launch(2'd1, 0, 0, 32'd1000, 32'd10, 3'd1, 3'd2, 0);
        edges = 1;
        repeat (3) begin @(posedge clk); #1; edges++; end
        launch(2'd0, 1, 0, 32'd77, 32'd0, 3'd7, 3'd7, 1);
        edges++;
        while (!done && edges < 100) begin @(posedge clk); #1; edges++; end
        chk("R10", "busy ignore latency", edges, 33);
        chk("R10", "busy ignore trap", trap_div0, 1'b0);
        chk("R10", "busy ignore quotient", {wr_b_en, wr_b_idx, wr_b_data}, {1'b1, 3'd1, 32'd100});
        chk("R10", "busy ignore remainder", {wr_a_en, wr_a_idx, wr_a_data}, {1'b1, 3'd2, 32'd0});
        @(posedge clk); #1;
        chk("R10", "no second run", {busy, done}, 2'b00);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_word();
        t_word_signed();
        t_long();
        t_quad();
        t_div0();
        t_same_idx();
        t_busy_ignore();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

endmodule